// File: doc/BRIEF.md
# UART Software Flow Controller

This block sits between a pair of byte queues and a byte-wide serial transmitter and receiver, and applies software (XON/XOFF) flow control. On the send side it reads the head of the transmit queue, pops it with a one-cycle pulse, and hands bytes to the transmitter with a strobe. When the transmitter is ready, the strobe is qualified so that each strobe cycle is exactly one accepted byte. On the receive side it forwards each received byte into the receive queue, provided that queue has room. It also raises a sticky overflow flag whenever a byte arrives while the receive queue is full.

The receive queue reports a coarse fill level that is `FILL_W` bits wide. The block compares this level against two thresholds, each given as a fraction of 2^`FILL_W`. When the level climbs to the high threshold, the block sends one pause code (XOFF). When the level drains to exactly the low threshold, it sends one resume code (XON). A pending control code is sent ahead of user data. User bytes that match either control code are popped and thrown away, so they can never reach the line. After reset the block behaves as if a pause had already been sent. It therefore sends a resume code as soon as the level sits at the low threshold.

Top module: `uart_swfc_ctrl`

## Requirements
- R1: After reset the overflow flag is 0 and a pause is considered outstanding. With default parameters, a fill level of 1 and a ready transmitter, the first strobe carries the resume code 0x11.
- R2: When the fill level is at or above the high threshold (12 of 16 by default), no pause is outstanding and the transmitter is ready, the strobe carries the pause code 0x13 in that cycle.
- R3: When the fill level equals the low threshold exactly (1 by default), a pause is outstanding and the transmitter is ready, the strobe carries the resume code 0x11.
- R4: While a pause or resume code is due, the transmit queue is not popped. The pause code takes precedence over the resume code, and both take precedence over user data.
- R5: With no code due, a valid queue head and a ready transmitter, the queue is popped in that cycle. The strobe carries the head byte, unless that byte is 0x11 or 0x13.
- R6: A user byte equal to 0x11 or 0x13 is popped without raising the strobe, so the byte is discarded.
- R7: Neither the strobe nor the pop is asserted while the transmitter is not ready.
- R8: A receive strobe pushes its byte unchanged into the receive queue in the same cycle, but only when the queue is not full.
- R9: A receive strobe while the queue is full sets the overflow flag from the next cycle onward. Only reset clears the flag.
- R10: Exactly one pause code is sent per climb to the high threshold, and exactly one resume code per drain to the low threshold. The two codes alternate on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| txq_valid | input | 1 | Transmit queue head is valid |
| txq_byte | input | 8 | Transmit queue head byte |
| txq_pop | output | 1 | Pop the transmit queue head |
| ser_tx_ready | input | 1 | Transmitter can accept a byte |
| ser_tx_stb | output | 1 | Byte handed to transmitter |
| ser_tx_byte | output | 8 | Byte for the transmitter |
| ser_rx_stb | input | 1 | Receiver has a new byte |
| ser_rx_byte | input | 8 | Received byte |
| rxq_full | input | 1 | Receive queue is full |
| rxq_level | input | FILL_W | Quantized receive queue fill level |
| rxq_push | output | 1 | Write to the receive queue |
| rxq_byte | output | 8 | Byte written to the receive queue |
| ovf_flag | output | 1 | Sticky receive overflow |

## Verification
The hardest case to reach is a control code being due in the same cycle as a valid user byte that is itself a control code, all while the transmitter's ready signal toggles. A purely random fill level rarely lands on the exact low threshold after having passed the high one. The stimulus therefore mixes random cycles, in which the level is biased toward both thresholds, with directed sweeps that ramp the level fully up and back down several times. The pause and resume codes are counted on each sweep. A per-cycle reference model, built from the requirements, checks every output on every cycle.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_XOFF = 2'd1,
    SRC_XON  = 2'd2,
    SRC_USER = 2'd3
  } tx_src_e;

  function automatic logic is_code(input byte_t b, input byte_t on_c, input byte_t off_c);
    return (b == on_c) || (b == off_c);
  endfunction
endpackage

// File: rtl/swfc_level_watch.sv
module swfc_level_watch #(
  parameter int FILL_W   = 4,
  parameter int HI_LVL   = 12,
  parameter int LO_LVL   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILL_W-1:0] level,
  input  logic              tx_ready,
  output logic              want_xoff,
  output logic              want_xon
);
  localparam logic [FILL_W:0] HI_THR = (FILL_W+1)'(HI_LVL);
  localparam logic [FILL_W:0] LO_THR = (FILL_W+1)'(LO_LVL);

  logic [FILL_W:0] lvl_ext;
  logic            at_hi, at_lo;
  logic            paused_q, paused_d, paused_en;

  assign lvl_ext = {1'b0, level};
  assign at_hi   = (lvl_ext >= HI_THR);
  assign at_lo   = (lvl_ext == LO_THR);

  always_comb begin
    want_xoff = at_hi & ~paused_q;
    want_xon  = at_lo &  paused_q;
    paused_en = 1'b0;
    paused_d  = paused_q;
    if (tx_ready && at_hi) begin
      paused_en = 1'b1;
      paused_d  = 1'b1;
    end else if (tx_ready && at_lo && paused_q) begin
      paused_en = 1'b1;
      paused_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         paused_q <= 1'b1;
    else if (paused_en) paused_q <= paused_d;
  end
endmodule

// File: rtl/swfc_tx_sel.sv
module swfc_tx_sel
  import swfc_pkg::*;
#(
  parameter byte_t ON_CODE  = 8'h11,
  parameter byte_t OFF_CODE = 8'h13
) (
  input  logic  want_xoff,
  input  logic  want_xon,
  input  logic  q_valid,
  input  byte_t q_byte,
  input  logic  tx_ready,
  output logic  tx_stb,
  output byte_t tx_byte,
  output logic  q_pop
);
  tx_src_e src;
  logic    drop_user;

  assign drop_user = is_code(q_byte, ON_CODE, OFF_CODE);

  always_comb begin
    if (want_xoff)    src = SRC_XOFF;
    else if (want_xon) src = SRC_XON;
    else if (q_valid)  src = SRC_USER;
    else               src = SRC_NONE;
  end

  always_comb begin
    tx_stb  = 1'b0;
    tx_byte = q_byte;
    q_pop   = 1'b0;
    case (src)
      SRC_XOFF: begin
        tx_stb  = tx_ready;
        tx_byte = OFF_CODE;
      end
      SRC_XON: begin
        tx_stb  = tx_ready;
        tx_byte = ON_CODE;
      end
      SRC_USER: begin
        q_pop  = tx_ready;
        tx_stb = tx_ready & ~drop_user;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/swfc_rx_guard.sv
module swfc_rx_guard
  import swfc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rx_stb,
  input  byte_t rx_byte,
  input  logic  q_full,
  output logic  q_push,
  output byte_t q_byte,
  output logic  ovf
);
  logic ovf_q, ovf_set;

  assign q_push  = rx_stb & ~q_full;
  assign q_byte  = rx_byte;
  assign ovf_set = rx_stb & q_full;
  assign ovf     = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_q <= 1'b0;
    else if (ovf_set) ovf_q <= 1'b1;
  end
endmodule

// File: rtl/uart_swfc_ctrl.sv
module uart_swfc_ctrl
  import swfc_pkg::*;
#(
  parameter int    FILL_W    = 4,
  parameter byte_t XON_CODE  = 8'h11,
  parameter byte_t XOFF_CODE = 8'h13,
  parameter real   XOFF_FRAC = 0.75,
  parameter real   XON_FRAC  = 0.0625
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txq_valid,
  input  logic [7:0]        txq_byte,
  output logic              txq_pop,
  input  logic              ser_tx_ready,
  output logic              ser_tx_stb,
  output logic [7:0]        ser_tx_byte,
  input  logic              ser_rx_stb,
  input  logic [7:0]        ser_rx_byte,
  input  logic              rxq_full,
  input  logic [FILL_W-1:0] rxq_level,
  output logic              rxq_push,
  output logic [7:0]        rxq_byte,
  output logic              ovf_flag
);
  localparam int RANGE  = 2 ** FILL_W;
  localparam int HI_LVL = int'(XOFF_FRAC * real'(RANGE));
  localparam int LO_LVL = int'(XON_FRAC * real'(RANGE));

  logic want_xoff, want_xon;

  swfc_level_watch #(
    .FILL_W (FILL_W),
    .HI_LVL (HI_LVL),
    .LO_LVL (LO_LVL)
  ) watch_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (rxq_level),
    .tx_ready  (ser_tx_ready),
    .want_xoff (want_xoff),
    .want_xon  (want_xon)
  );

  swfc_tx_sel #(
    .ON_CODE  (XON_CODE),
    .OFF_CODE (XOFF_CODE)
  ) sel_i (
    .want_xoff (want_xoff),
    .want_xon  (want_xon),
    .q_valid   (txq_valid),
    .q_byte    (txq_byte),
    .tx_ready  (ser_tx_ready),
    .tx_stb    (ser_tx_stb),
    .tx_byte   (ser_tx_byte),
    .q_pop     (txq_pop)
  );

  swfc_rx_guard rx_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_stb  (ser_rx_stb),
    .rx_byte (ser_rx_byte),
    .q_full  (rxq_full),
    .q_push  (rxq_push),
    .q_byte  (rxq_byte),
    .ovf     (ovf_flag)
  );
endmodule

// File: rtl/swfc_ctrl_chk.sv
module swfc_ctrl_chk #(
  parameter logic [7:0] XON_CODE  = 8'h11,
  parameter logic [7:0] XOFF_CODE = 8'h13
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ser_tx_ready,
  input logic       ser_tx_stb,
  input logic [7:0] ser_tx_byte,
  input logic       txq_pop,
  input logic [7:0] txq_byte,
  input logic       ser_rx_stb,
  input logic       rxq_full,
  input logic       rxq_push,
  input logic       ovf_flag
);
  // Line-side record of the last control code sent; reset mirrors a sent pause.
  logic off_sent;
  logic sent_off, sent_on;

  assign sent_off = ser_tx_stb && (ser_tx_byte == XOFF_CODE);
  assign sent_on  = ser_tx_stb && (ser_tx_byte == XON_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        off_sent <= 1'b1;
    else if (sent_off) off_sent <= 1'b1;
    else if (sent_on)  off_sent <= 1'b0;
  end

  p_idle_when_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_tx_ready |-> (!ser_tx_stb && !txq_pop));

  p_code_blocks_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_off || sent_on) |-> !txq_pop);

  p_drop_user_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (txq_pop && (txq_byte == XON_CODE || txq_byte == XOFF_CODE)) |-> !ser_tx_stb);

  p_push_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_push |-> (ser_rx_stb && !rxq_full));

  p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_rx_stb && rxq_full) |=> ovf_flag);

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  p_alt_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sent_off |-> !off_sent);

  p_alt_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sent_on |-> off_sent);
endmodule

bind uart_swfc_ctrl swfc_ctrl_chk #(
  .XON_CODE  (XON_CODE),
  .XOFF_CODE (XOFF_CODE)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .ser_tx_ready (ser_tx_ready),
  .ser_tx_stb   (ser_tx_stb),
  .ser_tx_byte  (ser_tx_byte),
  .txq_pop      (txq_pop),
  .txq_byte     (txq_byte),
  .ser_rx_stb   (ser_rx_stb),
  .rxq_full     (rxq_full),
  .rxq_push     (rxq_push),
  .ovf_flag     (ovf_flag)
);

// File: tb/uart_swfc_ctrl_tb_top.sv
module uart_swfc_ctrl_tb_top;
  localparam int FW     = 4;
  localparam int HI     = 12;
  localparam int LO     = 1;
  localparam logic [7:0] C_ON  = 8'h11;
  localparam logic [7:0] C_OFF = 8'h13;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          txq_valid, txq_pop, ser_tx_ready, ser_tx_stb;
  logic [7:0]    txq_byte, ser_tx_byte, ser_rx_byte, rxq_byte;
  logic          ser_rx_stb, rxq_full, rxq_push, ovf_flag;
  logic [FW-1:0] rxq_level;

  int  n_chk = 0, n_fail = 0;
  int  n_off = 0, n_on = 0;
  bit  m_paused, m_ovf, done = 0;

  always #4 clk = ~clk;

  uart_swfc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .txq_valid(txq_valid), .txq_byte(txq_byte),
    .txq_pop(txq_pop), .ser_tx_ready(ser_tx_ready), .ser_tx_stb(ser_tx_stb),
    .ser_tx_byte(ser_tx_byte), .ser_rx_stb(ser_rx_stb), .ser_rx_byte(ser_rx_byte),
    .rxq_full(rxq_full), .rxq_level(rxq_level), .rxq_push(rxq_push),
    .rxq_byte(rxq_byte), .ovf_flag(ovf_flag)
  );

  function automatic bit is_code(input logic [7:0] b);
    return (b == C_ON) || (b == C_OFF);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle, check outputs against the requirement model, then advance the model.
  task automatic step(input bit rdy, input bit v, input logic [7:0] b, input int lvl,
                      input bit rs, input logic [7:0] rb, input bit full);
    bit xo, xn, e_stb, e_pop, e_push;
    logic [7:0] e_byte;
    @(negedge clk);
    ser_tx_ready = rdy; txq_valid = v; txq_byte = b; rxq_level = FW'(lvl);
    ser_rx_stb = rs; ser_rx_byte = rb; rxq_full = full;
    xo     = (lvl >= HI) && !m_paused;
    xn     = (lvl == LO) && m_paused;
    e_stb  = rdy && (xo || xn || (v && !is_code(b)));
    e_byte = xo ? C_OFF : (xn ? C_ON : b);
    e_pop  = rdy && !xo && !xn && v;
    e_push = rs && !full;
    #2;
    chk(ser_tx_stb == e_stb, xo ? "R2" : (xn ? "R3" : (v && is_code(b) ? "R6" : "R5")),
        int'(ser_tx_stb), int'(e_stb));
    if (e_stb) chk(ser_tx_byte == e_byte, "R4", int'(ser_tx_byte), int'(e_byte));
    chk(txq_pop == e_pop, rdy ? "R4" : "R7", int'(txq_pop), int'(e_pop));
    chk(rxq_push == e_push, "R8", int'(rxq_push), int'(e_push));
    if (e_push) chk(rxq_byte == rb, "R8", int'(rxq_byte), int'(rb));
    chk(ovf_flag == m_ovf, "R9", int'(ovf_flag), int'(m_ovf));
    if (ser_tx_stb && ser_tx_byte == C_OFF) n_off++;
    if (ser_tx_stb && ser_tx_byte == C_ON)  n_on++;
    @(posedge clk);
    if (rdy && lvl >= HI) m_paused = 1'b1;
    else if (rdy && lvl == LO) m_paused = 1'b0;
    if (rs && full) m_ovf = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_paused = 1'b1; m_ovf = 1'b0;
  endtask

  initial begin
    int lvl;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; ser_tx_ready = 0; txq_valid = 0; txq_byte = 0; rxq_level = 0;
    ser_rx_stb = 0; ser_rx_byte = 0; rxq_full = 0;
    do_reset();
    // R1: reset state and first resume code
    #1 chk(ovf_flag == 1'b0, "R1", int'(ovf_flag), 0);
    step(1, 1, 8'h41, LO, 0, 8'h00, 0);
    chk(n_on == 1, "R1", n_on, 1);
    // R7: busy transmitter, high level
    step(0, 1, 8'h42, 15, 0, 8'h00, 0);
    // R2, R10: one pause per climb, one resume per drain
    for (int s = 0; s < 4; s++) begin
      n_off = 0; n_on = 0;
      for (int k = 0; k < 16; k++) step(1, 1, 8'h30 + 8'(k), k, 0, 8'h00, 0);
      for (int k = 15; k >= 0; k--) step(1, 1, 8'h50, k, 0, 8'h00, 0);
      chk(n_off == 1, "R10", n_off, 1);
      chk(n_on == 1, "R10", n_on, 1);
    end
    // R6: user control codes dropped
    step(1, 1, C_OFF, 5, 0, 8'h00, 0);
    step(1, 1, C_ON, 5, 0, 8'h00, 0);
    // R8, R9: push and overflow
    step(1, 0, 8'h00, 5, 1, 8'h9a, 0);
    step(1, 0, 8'h00, 5, 1, 8'h9b, 1);
    step(1, 0, 8'h00, 5, 0, 8'h00, 0);
    do_reset();
    #1 chk(ovf_flag == 1'b0, "R9", int'(ovf_flag), 0);
    // Random phase with the level biased toward both thresholds
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] b;
      int r = $urandom_range(0, 9);
      lvl = (r < 3) ? LO : ((r < 6) ? $urandom_range(HI, 15) : $urandom_range(0, 15));
      b = ($urandom_range(0, 3) == 0) ? (($urandom_range(0, 1) == 1) ? C_ON : C_OFF)
                                      : 8'($urandom);
      step($urandom_range(0, 3) != 0, $urandom_range(0, 4) != 0, b, lvl,
           $urandom_range(0, 2) == 0, 8'($urandom), $urandom_range(0, 9) == 0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule